// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block refills a translation cache after a miss. The requester presents a 32-bit virtual address together with a start pulse. The walker then fetches one entry from the first-level table and, if that entry links to a second table, one entry from that table. It uses a plain request/response port into physical memory to do this. The first-level table starts at the page given by a root-pointer input. The walker makes only one walk at a time, and it ignores new start pulses while it is busy.

A walk ends in one of two ways. It can end with a leaf translation for the refill: the physical page number, the four permission bits, and the virtual page number that was walked. Otherwise it ends with a page-fault indication that goes back to the requester, who must resolve it. Superpages, accessed/dirty updates and caching of table entries are not provided.

Top module: `ptw_walker`

## Requirements
- R1: After reset, and whenever it is idle, the walker holds walk_busy_o, req_valid_o, walk_done_o and walk_fault_o low.
- R2: The first memory request of a walk reads address (root_ppn_i << 12) + va[31:22]*4.
- R3: If the first-level entry is a link, the second request reads address (entry[31:10] << 12) + va[21:12]*4. An entry is a link when bit 0 (valid) is 1 and bits 3:1 (read, write, execute) are all 0.
- R4: A second-level entry that is valid with at least one of bits 3:1 set is a leaf. It ends the walk with a one-cycle walk_done_o. With it, refill_ppn_o = entry[31:10] and refill_perm_o = entry[4:1], so perm bit 0 is read, 1 is write, 2 is execute and 3 is user.
- R5: A first-level entry with bit 0 clear ends the walk with a one-cycle walk_fault_o, and no second request is issued.
- R6: A first-level leaf (valid, any of bits 3:1 set) is a fault, because superpages are unsupported. No second request is issued.
- R7: A second-level entry that is invalid, or that is a link, ends the walk with walk_fault_o.
- R8: Once req_valid_o is high, it stays high with req_addr_o unchanged until req_ready_i accepts it.
- R9: A start pulse while walk_busy_o is high is ignored. The running walk keeps its address, and no extra requests follow.
- R10: walk_done_o and walk_fault_o are never high together, each lasts exactly one cycle, the walker is idle in the next cycle, and refill_vpn_o equals va[31:12] of the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| root_ppn_i | input | 22 | Page number of the first-level table |
| walk_start_i | input | 1 | Start a walk (used only when idle) |
| walk_va_i | input | 32 | Virtual address that missed |
| walk_busy_o | output | 1 | A walk is in progress |
| walk_done_o | output | 1 | One-cycle pulse: leaf found |
| walk_fault_o | output | 1 | One-cycle pulse: page fault |
| refill_vpn_o | output | 20 | Virtual page number of the walk |
| refill_ppn_o | output | 22 | Physical page number of the leaf |
| refill_perm_o | output | 4 | {user, execute, write, read} of the leaf |
| req_valid_o | output | 1 | Memory read request |
| req_ready_i | input | 1 | Memory accepts the request |
| req_addr_o | output | 34 | Physical byte address of the entry |
| rsp_valid_i | input | 1 | Read data valid |
| rsp_data_i | input | 32 | Entry read from memory |

## Verification
The bench uses the default parameters: 10-bit indices, a 12-bit offset and a 22-bit page number. Physical addresses are therefore 34 bits wide, and randomly drawn root and link page numbers put table entries above the 4 GB line, where a truncated address would show. Random ready stalls and response delays of up to two cycles push the handshake hold rule and the waiting states into many timings. Random entry kinds at both levels reach every outcome of the walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE, ST_FAULT
  } walk_state_e;

  typedef enum logic [1:0] {PTE_INVALID, PTE_LINK, PTE_LEAF} pte_kind_e;

  localparam int unsigned PTE_V_BIT    = 0;
  localparam int unsigned PTE_PERM_LSB = 1;
  localparam int unsigned PTE_PERM_W   = 4;
  localparam int unsigned PTE_PPN_LSB  = 10;
endpackage

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode
  import ptw_pkg::*;
#(
  parameter int unsigned PTE_W = 32,
  parameter int unsigned PPN_W = 22
) (
  input  logic [PTE_W-1:0]      pte_i,
  output pte_kind_e             kind_o,
  output logic [PPN_W-1:0]      ppn_o,
  output logic [PTE_PERM_W-1:0] perm_o
);
  logic [2:0] rwx;

  assign rwx    = pte_i[PTE_PERM_LSB +: 3];
  assign ppn_o  = pte_i[PTE_PPN_LSB +: PPN_W];
  assign perm_o = pte_i[PTE_PERM_LSB +: PTE_PERM_W];

  always_comb begin
    if (!pte_i[PTE_V_BIT])  kind_o = PTE_INVALID;
    else if (rwx == 3'b000) kind_o = PTE_LINK;
    else                    kind_o = PTE_LEAF;
  end
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int unsigned PPN_W = 22,
  parameter int unsigned IDX_W = 10,
  parameter int unsigned OFF_W = 12,
  localparam int unsigned PA_W = PPN_W + OFF_W
) (
  input  logic [PPN_W-1:0] base_ppn_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [PA_W-1:0]  addr_o
);
  // 4-byte entries: table base plus index scaled by 4
  assign addr_o = {base_ppn_i, {OFF_W{1'b0}}} + PA_W'({idx_i, 2'b00});
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        req_ready_i,
  input  logic        rsp_valid_i,
  input  pte_kind_e   kind_i,
  output walk_state_e state_o
);
  walk_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_i) state_d = ST_L1_REQ;
      ST_L1_REQ:  if (req_ready_i) state_d = ST_L1_WAIT;
      ST_L1_WAIT: if (rsp_valid_i) state_d = (kind_i == PTE_LINK) ? ST_L2_REQ : ST_FAULT;
      ST_L2_REQ:  if (req_ready_i) state_d = ST_L2_WAIT;
      ST_L2_WAIT: if (rsp_valid_i) state_d = (kind_i == PTE_LEAF) ? ST_DONE : ST_FAULT;
      ST_DONE:    state_d = ST_IDLE;
      ST_FAULT:   state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  // R5/R6: a non-link first-level entry never leads to a second fetch
  assert_l1_fault_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_L1_WAIT && rsp_valid_i && kind_i != PTE_LINK) |=> state_q == ST_FAULT);

  assert_l2_leaf_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_L2_WAIT && rsp_valid_i && kind_i == PTE_LEAF) |=> state_q == ST_DONE);

  assert_l2_bad_fault_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_L2_WAIT && rsp_valid_i && kind_i != PTE_LEAF) |=> state_q == ST_FAULT);
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int unsigned IDX_W = 10,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned PPN_W = 22,
  parameter int unsigned PTE_W = 32,
  localparam int unsigned LEVELS = 2,
  localparam int unsigned VA_W   = LEVELS * IDX_W + OFF_W,
  localparam int unsigned VPN_W  = VA_W - OFF_W,
  localparam int unsigned PA_W   = PPN_W + OFF_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [PPN_W-1:0]      root_ppn_i,
  input  logic                  walk_start_i,
  input  logic [VA_W-1:0]       walk_va_i,
  output logic                  walk_busy_o,
  output logic                  walk_done_o,
  output logic                  walk_fault_o,
  output logic [VPN_W-1:0]      refill_vpn_o,
  output logic [PPN_W-1:0]      refill_ppn_o,
  output logic [PTE_PERM_W-1:0] refill_perm_o,
  output logic                  req_valid_o,
  input  logic                  req_ready_i,
  output logic [PA_W-1:0]       req_addr_o,
  input  logic                  rsp_valid_i,
  input  logic [PTE_W-1:0]      rsp_data_i
);
  walk_state_e           state;
  pte_kind_e             kind;
  logic [PPN_W-1:0]      pte_ppn;
  logic [PTE_PERM_W-1:0] pte_perm;
  logic [VPN_W-1:0]      vpn_q;
  logic [PPN_W-1:0]      l2_base_q;
  logic [PPN_W-1:0]      ppn_q;
  logic [PTE_PERM_W-1:0] perm_q;
  logic [PPN_W-1:0]      lvl_base [LEVELS];
  logic [PA_W-1:0]       lvl_addr [LEVELS];

  ptw_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (walk_start_i),
    .req_ready_i (req_ready_i),
    .rsp_valid_i (rsp_valid_i),
    .kind_i      (kind),
    .state_o     (state)
  );

  ptw_pte_decode #(.PTE_W(PTE_W), .PPN_W(PPN_W)) u_dec (
    .pte_i  (rsp_data_i),
    .kind_o (kind),
    .ppn_o  (pte_ppn),
    .perm_o (pte_perm)
  );

  assign lvl_base[0] = root_ppn_i;
  assign lvl_base[1] = l2_base_q;

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    ptw_addr_gen #(.PPN_W(PPN_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_ag (
      .base_ppn_i (lvl_base[l]),
      .idx_i      (vpn_q[VPN_W-1-l*IDX_W -: IDX_W]),
      .addr_o     (lvl_addr[l])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vpn_q     <= '0;
      l2_base_q <= '0;
      ppn_q     <= '0;
      perm_q    <= '0;
    end else begin
      if (state == ST_IDLE && walk_start_i)
        vpn_q <= walk_va_i[VA_W-1:OFF_W];
      if (state == ST_L1_WAIT && rsp_valid_i && kind == PTE_LINK)
        l2_base_q <= pte_ppn;
      if (state == ST_L2_WAIT && rsp_valid_i && kind == PTE_LEAF) begin
        ppn_q  <= pte_ppn;
        perm_q <= pte_perm;
      end
    end
  end

  assign req_valid_o   = (state == ST_L1_REQ) || (state == ST_L2_REQ);
  assign req_addr_o    = (state == ST_L2_REQ) ? lvl_addr[1] : lvl_addr[0];
  assign walk_busy_o   = (state != ST_IDLE);
  assign walk_done_o   = (state == ST_DONE);
  assign walk_fault_o  = (state == ST_FAULT);
  assign refill_vpn_o  = vpn_q;
  assign refill_ppn_o  = ppn_q;
  assign refill_perm_o = perm_q;

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !walk_busy_o |-> (!req_valid_o && !walk_done_o && !walk_fault_o));

  assert_req_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o)));

  assert_start_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (walk_busy_o && walk_start_i) |=> $stable(refill_vpn_o));

  assert_one_result_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({walk_done_o, walk_fault_o}));

  assert_result_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (walk_done_o || walk_fault_o) |=> (!walk_busy_o && !walk_done_o && !walk_fault_o));
endmodule

// File: tb/ptw_walker_tb.sv
`timescale 1ns/1ps
module ptw_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [21:0] root_ppn = '0;
  logic        start = 1'b0;
  logic [31:0] va = '0;
  logic        busy, done, fault;
  logic [19:0] vpn;
  logic [21:0] ppn;
  logic [3:0]  perm;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic [33:0] req_addr;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_data = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [31:0] mem [logic [33:0]];
  logic [33:0] req_log [4];
  int          req_cnt = 0;

  always #2.5 clk = ~clk;

  ptw_walker dut_i (
    .clk_i(clk), .rst_ni(rst_n), .root_ppn_i(root_ppn),
    .walk_start_i(start), .walk_va_i(va),
    .walk_busy_o(busy), .walk_done_o(done), .walk_fault_o(fault),
    .refill_vpn_o(vpn), .refill_ppn_o(ppn), .refill_perm_o(perm),
    .req_valid_o(req_valid), .req_ready_i(req_ready), .req_addr_o(req_addr),
    .rsp_valid_i(rsp_valid), .rsp_data_i(rsp_data)
  );

  function automatic logic [31:0] mem_rd(logic [33:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory responder, hold-rule monitor (R8)
  initial begin
    bit          pend = 0;
    int          dly = 0;
    logic [33:0] paddr = '0;
    bit          stalled = 0;
    logic [33:0] stall_addr = '0;
    forever begin
      @(negedge clk);
      if (stalled) begin
        chk(req_valid, "R8", "valid held", req_valid, 1);
        chk(req_addr == stall_addr, "R8", "addr held", req_addr, stall_addr);
      end
      rsp_valid = 1'b0;
      if (pend) begin
        if (dly == 0) begin
          rsp_valid = 1'b1;
          rsp_data  = mem_rd(paddr);
          pend = 0;
        end else dly--;
      end
      req_ready = ($urandom % 4) != 0;
      stalled = req_valid && !req_ready && rst_n;
      stall_addr = req_addr;
      if (req_valid && req_ready && rst_n) begin
        if (req_cnt < 4) req_log[req_cnt] = req_addr;
        req_cnt++;
        paddr = req_addr;
        pend = 1;
        dly = $urandom % 3;
      end
    end
  end

  function automatic logic [33:0] l1_addr(logic [31:0] v);
    return {root_ppn, 12'h0} + 34'(v[31:22]) * 4;
  endfunction

  task automatic run_walk(input logic [31:0] v, input bit extra_start, input string req);
    logic [31:0] p1, p2;
    logic [33:0] a1, a2;
    bit          exp_fault;
    int          exp_n;
    bit          got_done, got_fault;
    a1 = l1_addr(v);
    p1 = mem_rd(a1);
    a2 = {p1[31:10], 12'h0} + 34'(v[21:12]) * 4;
    p2 = mem_rd(a2);
    if (!p1[0] || p1[3:1] != 0) begin exp_fault = 1; exp_n = 1; end
    else begin exp_n = 2; exp_fault = !(p2[0] && p2[3:1] != 0); end

    req_cnt = 0;
    @(negedge clk);
    start = 1'b1; va = v;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 100; c++) begin
      if (done || fault) break;
      if (extra_start && c == 1) begin start = 1'b1; va = ~v; end
      if (c == 2) start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    got_done = done; got_fault = fault;
    chk(got_done ^ got_fault, "R10", "exactly one result", {got_done, got_fault}, exp_fault ? 1 : 2);
    chk(got_fault == exp_fault, req, "fault outcome", got_fault, exp_fault);
    chk(vpn == v[31:12], "R10", "refill vpn", vpn, v[31:12]);
    chk(req_cnt == exp_n, extra_start ? "R9" : req, "request count", req_cnt, exp_n);
    chk(req_log[0] == a1, "R2", "l1 addr", req_log[0], a1);
    if (exp_n == 2) chk(req_log[1] == a2, "R3", "l2 addr", req_log[1], a2);
    if (!exp_fault) begin
      chk(ppn == p2[31:10], "R4", "ppn", ppn, p2[31:10]);
      chk(perm == p2[4:1], "R4", "perm", perm, p2[4:1]);
    end
    @(negedge clk);
    chk(!done && !fault && !busy, "R10", "pulse ends, idle", {done, fault, busy}, 0);
  endtask

  // build tables: k1 0=invalid 1=leaf 2=link, k2 same for level 2
  task automatic setup(input logic [31:0] v, input int k1, input int k2);
    logic [21:0] nxt;
    logic [33:0] a2;
    logic [2:0]  rwx;
    nxt = 22'($urandom);
    rwx = 3'($urandom % 7) + 3'd1;
    case (k1)
      0: mem[l1_addr(v)] = {22'($urandom), 9'($urandom), 1'b0};
      1: mem[l1_addr(v)] = {nxt, 5'($urandom), 1'($urandom), rwx, 1'b1};
      default: mem[l1_addr(v)] = {nxt, 5'($urandom), 1'($urandom), 3'b000, 1'b1};
    endcase
    a2 = {nxt, 12'h0} + 34'(v[21:12]) * 4;
    case (k2)
      0: mem[a2] = {22'($urandom), 9'($urandom), 1'b0};
      1: mem[a2] = {22'($urandom), 5'($urandom), 1'($urandom), rwx, 1'b1};
      default: mem[a2] = {22'($urandom), 5'($urandom), 1'($urandom), 3'b000, 1'b1};
    endcase
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finished");
    if (!finished) $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5eed_1234));
    root_ppn = 22'h3f_1a2c;
    repeat (3) @(negedge clk);
    chk(!busy && !req_valid && !done && !fault, "R1", "reset idle", {busy, req_valid, done, fault}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !req_valid, "R1", "idle after reset", {busy, req_valid}, 0);

    v = 32'hffc0_1abc; setup(v, 2, 1); run_walk(v, 0, "R4");
    v = 32'h0000_0123; setup(v, 2, 1); run_walk(v, 0, "R4");
    v = 32'h1234_5678; setup(v, 0, 1); run_walk(v, 0, "R5");
    v = 32'h8765_4321; setup(v, 1, 1); run_walk(v, 0, "R6");
    v = 32'h4444_8000; setup(v, 2, 0); run_walk(v, 0, "R7");
    v = 32'h5555_9000; setup(v, 2, 2); run_walk(v, 0, "R7");
    v = 32'h6666_a000; setup(v, 2, 1); run_walk(v, 1, "R9");
    v = 32'h7777_b000; setup(v, 0, 0); run_walk(v, 1, "R9");

    for (int i = 0; i < 300; i++) begin
      v = $urandom;
      if (i % 50 == 0) root_ppn = 22'($urandom);
      setup(v, $urandom % 3, $urandom % 3);
      run_walk(v, (i % 7) == 0, "R4");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule